// File: doc/BRIEF.md
# System Control Register Block

This block is a small group of I/O-mapped control registers on an 8-bit port bus. It records why the processor was last reset, takes software requests for reset, power-off and NMI-vector protection, and holds the mode bits that other parts of the chip consume. These are the video-memory DMA mode, the dictionary and boot-ROM mapping selects, and a character-glyph enable. It also gates an external NMI through a mask and offers a bit-banged port for a serial identification ROM.

Software reads and writes the registers with single-cycle strobes. Read data is combinational while the read strobe is high, and any side effect of the read takes effect at the clock edge that ends that cycle. A separate notification input tells the block that the processor has just been reset by hardware. The block then records the event and restores its mapping bits to their boot values.

Top module: `sys_ctrl_regs`

## Requirements
- R1: A write to the control port (0x0020) loads NMI-vector protect from data bit 7, the software-reset flag from bit 0 and the power-off status from bit 6.
- R2: A read of the control port returns the software-reset flag on bit 0, the hardware-reset flag on bit 1, the power-off status on bit 2 and zero on bits 7:3. The read clears bits 0 and 1 and leaves bit 2 unchanged.
- R3: `powerOffReq` is high for exactly the one cycle after the edge that accepts a control-port write with bit 6 set.
- R4: A write to the mode port (0x0404) with bit 7 = 0 selects VRAM mode (`vramMode` = 1), and bit 7 = 1 deselects it. A read returns 0x00 in VRAM mode and 0x80 otherwise.
- R5: A write to the map port (0x0480) sets `dictSel` from bit 0 and clears `romSel` when bit 1 is 1 (active-low). A read returns `dictSel` on bit 0 and the inverse of `romSel` on bit 1.
- R6: A write to the mask port (0x05C0) with bit 3 = 0 masks the external NMI, and bit 3 = 1 unmasks it. A read returns 0x00 while masked and 0x08 while unmasked.
- R7: `extNmiIn` is registered once. The status port (0x05C2) reads 0x08 while the registered level is high and 0x00 otherwise. `nmiOut` equals the registered level while unmasked and is 0 while masked.
- R8: A write to the serial-ROM port (0x0032) drives `romCs` from the inverse of bit 5, `romClk` from bit 6 and `romRst` from bit 7. A read returns the `romRst` level on bit 7, the `romClk` level on bit 6, `romDataIn` on bit 0 and zero elsewhere.
- R9: A write to the glyph port (0xFF99) sets `glyphEn` from bit 0. A read returns it on bit 0, with zero on the other bits.
- R10: A high `cpuResetNotify` at a clock edge sets the hardware-reset flag and clears `nmiVecProtect`, `glyphEn` and `dictSel`, and it sets `romSel`. It wins over a write or a clearing read in the same cycle.
- R11: A read of any port not listed above returns 0xFF. `portRdData` is 0x00 whenever `portRd` is low.
- R12: After reset all flags are 0, `vramMode` = 0, `dictSel` = 0, `romSel` = 1, the NMI is masked, `romCs` = 1 and `romClk` = `romRst` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| portAddr | input | 16 | Port address |
| portWrData | input | 8 | Write data |
| portWr | input | 1 | Write strobe, one cycle per write |
| portRd | input | 1 | Read strobe, one cycle per read |
| portRdData | output | 8 | Read data, valid while portRd is high |
| extNmiIn | input | 1 | External NMI level |
| cpuResetNotify | input | 1 | Processor hardware-reset notification |
| romDataIn | input | 1 | Serial ID ROM data line |
| nmiVecProtect | output | 1 | NMI-vector protect bit |
| powerOffReq | output | 1 | One-cycle power-off request |
| vramMode | output | 1 | DMA targets video memory |
| dictSel | output | 1 | Dictionary mapped in |
| romSel | output | 1 | Boot ROM mapped in |
| glyphEn | output | 1 | Character-glyph access enabled |
| romCs | output | 1 | Serial ROM chip select |
| romClk | output | 1 | Serial ROM clock |
| romRst | output | 1 | Serial ROM reset |
| nmiOut | output | 1 | Gated NMI to the processor |

## Verification
The bench builds the block with its default 16-bit address and the default port addresses. With these settings every one of the 256 data values can be written to each register and read back. Each read-to-clear case can be followed from one access to the next. All of the low system-port range and the whole upper port page can be swept to show that only the seven decoded addresses respond. Masking, notification priority and power-off pulse timing are checked against expectations the bench computes from the data values it drives.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

  localparam int DATA_W = 8;

  // read source; order matches the decoder's port table (index + 1)
  typedef enum logic [2:0] {
    SEL_NONE    = 3'd0,
    SEL_CTRL    = 3'd1,
    SEL_ROMIO   = 3'd2,
    SEL_MODE    = 3'd3,
    SEL_MAP     = 3'd4,
    SEL_MASK    = 3'd5,
    SEL_NMISTAT = 3'd6,
    SEL_GLYPH   = 3'd7
  } rdSel_e;

  typedef struct packed {
    logic   wrCtrl;
    logic   wrRomIo;
    logic   wrMode;
    logic   wrMap;
    logic   wrMask;
    logic   wrGlyph;
    logic   rdCtrl;
    logic   rdActive;
    rdSel_e rdSel;
  } regStrobe_t;

endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
  import sysctl_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] CTRL_PORT    = 16'h0020,
  parameter logic [ADDR_W-1:0] ROMIO_PORT   = 16'h0032,
  parameter logic [ADDR_W-1:0] MODE_PORT    = 16'h0404,
  parameter logic [ADDR_W-1:0] MAP_PORT     = 16'h0480,
  parameter logic [ADDR_W-1:0] MASK_PORT    = 16'h05C0,
  parameter logic [ADDR_W-1:0] NMISTAT_PORT = 16'h05C2,
  parameter logic [ADDR_W-1:0] GLYPH_PORT   = 16'hFF99
) (
  input  logic [ADDR_W-1:0] portAddr,
  input  logic              portWr,
  input  logic              portRd,
  output regStrobe_t        strobe
);

  localparam int NUM_PORTS = 7;
  localparam logic [ADDR_W-1:0] PORT_TAB [NUM_PORTS] = '{
    CTRL_PORT, ROMIO_PORT, MODE_PORT, MAP_PORT, MASK_PORT, NMISTAT_PORT, GLYPH_PORT
  };

  logic [NUM_PORTS-1:0] hit;

  genvar g;
  generate
    for (g = 0; g < NUM_PORTS; g++) begin : g_match
      assign hit[g] = (portAddr == PORT_TAB[g]);
    end
  endgenerate

  always_comb begin
    strobe          = '0;
    strobe.rdSel    = SEL_NONE;
    for (int i = 0; i < NUM_PORTS; i++) begin
      if (hit[i]) strobe.rdSel = rdSel_e'(3'(i + 1));
    end
    strobe.rdActive = portRd;
    strobe.rdCtrl   = portRd & hit[0];
    strobe.wrCtrl   = portWr & hit[0];
    strobe.wrRomIo  = portWr & hit[1];
    strobe.wrMode   = portWr & hit[2];
    strobe.wrMap    = portWr & hit[3];
    strobe.wrMask   = portWr & hit[4];
    strobe.wrGlyph  = portWr & hit[6];
  end

endmodule

// File: rtl/sysctl_datapath.sv
module sysctl_datapath
  import sysctl_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        strobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic              extNmiIn,
  input  logic              cpuResetNotify,
  input  logic              romDataIn,
  output logic [DATA_W-1:0] rdData,
  output logic              nmiVecProtect,
  output logic              powerOffReq,
  output logic              vramMode,
  output logic              dictSel,
  output logic              romSel,
  output logic              glyphEn,
  output logic              romCs,
  output logic              romClk,
  output logic              romRst,
  output logic              nmiOut
);

  logic swResetFlag, hwResetFlag, poffStatus;
  logic romCsBit;
  logic nmiMasked, nmiLevel;
  logic [DATA_W-1:0] muxData;

  // cause flags and power control; notification has the last word
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      swResetFlag   <= 1'b0;
      hwResetFlag   <= 1'b0;
      poffStatus    <= 1'b0;
      nmiVecProtect <= 1'b0;
      powerOffReq   <= 1'b0;
    end else begin
      powerOffReq <= strobe.wrCtrl & wrData[6];
      if (strobe.wrCtrl) begin
        nmiVecProtect <= wrData[7];
        swResetFlag   <= wrData[0];
        poffStatus    <= wrData[6];
      end else if (strobe.rdCtrl) begin
        swResetFlag <= 1'b0;
      end
      if (strobe.rdCtrl) hwResetFlag <= 1'b0;
      if (cpuResetNotify) begin
        hwResetFlag   <= 1'b1;
        nmiVecProtect <= 1'b0;
      end
    end
  end

  // mapping and mode bits
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vramMode <= 1'b0;
      dictSel  <= 1'b0;
      romSel   <= 1'b1;
      glyphEn  <= 1'b0;
    end else begin
      if (strobe.wrMode)  vramMode <= ~wrData[7];
      if (strobe.wrMap) begin
        dictSel <= wrData[0];
        romSel  <= ~wrData[1];
      end
      if (strobe.wrGlyph) glyphEn <= wrData[0];
      if (cpuResetNotify) begin
        dictSel <= 1'b0;
        romSel  <= 1'b1;
        glyphEn <= 1'b0;
      end
    end
  end

  // serial ROM pins
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      romCsBit <= 1'b0;
      romClk   <= 1'b0;
      romRst   <= 1'b0;
    end else if (strobe.wrRomIo) begin
      romCsBit <= wrData[5];
      romClk   <= wrData[6];
      romRst   <= wrData[7];
    end
  end
  assign romCs = ~romCsBit;

  // extra NMI gate
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nmiMasked <= 1'b1;
      nmiLevel  <= 1'b0;
    end else begin
      nmiLevel <= extNmiIn;
      if (strobe.wrMask) nmiMasked <= ~wrData[3];
    end
  end
  assign nmiOut = nmiLevel & ~nmiMasked;

  // read mux
  always_comb begin
    unique case (strobe.rdSel)
      SEL_CTRL:    muxData = {5'b0, poffStatus, hwResetFlag, swResetFlag};
      SEL_ROMIO:   muxData = {romRst, romClk, 5'b0, romDataIn};
      SEL_MODE:    muxData = vramMode ? 8'h00 : 8'h80;
      SEL_MAP:     muxData = {6'b0, ~romSel, dictSel};
      SEL_MASK:    muxData = nmiMasked ? 8'h00 : 8'h08;
      SEL_NMISTAT: muxData = nmiLevel ? 8'h08 : 8'h00;
      SEL_GLYPH:   muxData = {7'b0, glyphEn};
      default:     muxData = 8'hFF;
    endcase
  end
  assign rdData = strobe.rdActive ? muxData : '0;

endmodule

// File: rtl/sys_ctrl_regs.sv
module sys_ctrl_regs
  import sysctl_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] CTRL_PORT    = 16'h0020,
  parameter logic [ADDR_W-1:0] ROMIO_PORT   = 16'h0032,
  parameter logic [ADDR_W-1:0] MODE_PORT    = 16'h0404,
  parameter logic [ADDR_W-1:0] MAP_PORT     = 16'h0480,
  parameter logic [ADDR_W-1:0] MASK_PORT    = 16'h05C0,
  parameter logic [ADDR_W-1:0] NMISTAT_PORT = 16'h05C2,
  parameter logic [ADDR_W-1:0] GLYPH_PORT   = 16'hFF99
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] portAddr,
  input  logic [7:0]        portWrData,
  input  logic              portWr,
  input  logic              portRd,
  output logic [7:0]        portRdData,
  input  logic              extNmiIn,
  input  logic              cpuResetNotify,
  input  logic              romDataIn,
  output logic              nmiVecProtect,
  output logic              powerOffReq,
  output logic              vramMode,
  output logic              dictSel,
  output logic              romSel,
  output logic              glyphEn,
  output logic              romCs,
  output logic              romClk,
  output logic              romRst,
  output logic              nmiOut
);

  regStrobe_t strobe;

  sysctl_decode #(
    .ADDR_W(ADDR_W), .CTRL_PORT(CTRL_PORT), .ROMIO_PORT(ROMIO_PORT),
    .MODE_PORT(MODE_PORT), .MAP_PORT(MAP_PORT), .MASK_PORT(MASK_PORT),
    .NMISTAT_PORT(NMISTAT_PORT), .GLYPH_PORT(GLYPH_PORT)
  ) i_decode (
    .portAddr(portAddr),
    .portWr  (portWr),
    .portRd  (portRd),
    .strobe  (strobe)
  );

  sysctl_datapath i_datapath (
    .clk           (clk),
    .rstN          (rstN),
    .strobe        (strobe),
    .wrData        (portWrData),
    .extNmiIn      (extNmiIn),
    .cpuResetNotify(cpuResetNotify),
    .romDataIn     (romDataIn),
    .rdData        (portRdData),
    .nmiVecProtect (nmiVecProtect),
    .powerOffReq   (powerOffReq),
    .vramMode      (vramMode),
    .dictSel       (dictSel),
    .romSel        (romSel),
    .glyphEn       (glyphEn),
    .romCs         (romCs),
    .romClk        (romClk),
    .romRst        (romRst),
    .nmiOut        (nmiOut)
  );

endmodule

// File: rtl/sys_ctrl_regs_checker.sv
module sys_ctrl_regs_checker #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] CTRL_PORT = 16'h0020,
  parameter logic [ADDR_W-1:0] MODE_PORT = 16'h0404,
  parameter logic [ADDR_W-1:0] MASK_PORT = 16'h05C0
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] portAddr,
  input logic [7:0]        portWrData,
  input logic              portWr,
  input logic              portRd,
  input logic [7:0]        portRdData,
  input logic              extNmiIn,
  input logic              cpuResetNotify,
  input logic              nmiVecProtect,
  input logic              powerOffReq,
  input logic              vramMode,
  input logic              dictSel,
  input logic              romSel,
  input logic              glyphEn,
  input logic              nmiOut
);

  logic rdCtrlNow;
  assign rdCtrlNow = portRd && (portAddr == CTRL_PORT);

  assert_clear_on_read_R2: assert property (@(posedge clk) disable iff (!rstN)
    (rdCtrlNow && !cpuResetNotify && !portWr) |=> (!rdCtrlNow || portRdData[1:0] == 2'b00));

  assert_poff_pulse_R3: assert property (@(posedge clk) disable iff (!rstN)
    powerOffReq |-> $past(portWr && portAddr == CTRL_PORT && portWrData[6]));

  assert_vram_select_R4: assert property (@(posedge clk) disable iff (!rstN)
    $past(portWr && portAddr == MODE_PORT && !portWrData[7]) |-> vramMode);

  assert_mask_blocks_R6: assert property (@(posedge clk) disable iff (!rstN)
    $past(portWr && portAddr == MASK_PORT && !portWrData[3]) |-> !nmiOut);

  assert_nmi_source_R7: assert property (@(posedge clk) disable iff (!rstN)
    nmiOut |-> $past(extNmiIn));

  assert_notify_restore_R10: assert property (@(posedge clk) disable iff (!rstN)
    $past(cpuResetNotify) |-> (romSel && !dictSel && !nmiVecProtect && !glyphEn));

endmodule

bind sys_ctrl_regs sys_ctrl_regs_checker #(
  .ADDR_W(ADDR_W), .CTRL_PORT(CTRL_PORT), .MODE_PORT(MODE_PORT), .MASK_PORT(MASK_PORT)
) i_checker (
  .clk(clk), .rstN(rstN), .portAddr(portAddr), .portWrData(portWrData),
  .portWr(portWr), .portRd(portRd), .portRdData(portRdData), .extNmiIn(extNmiIn),
  .cpuResetNotify(cpuResetNotify), .nmiVecProtect(nmiVecProtect),
  .powerOffReq(powerOffReq), .vramMode(vramMode), .dictSel(dictSel),
  .romSel(romSel), .glyphEn(glyphEn), .nmiOut(nmiOut)
);

// File: tb/test_sys_ctrl_regs.sv
`timescale 1ns/1ps
module test_sys_ctrl_regs;

  localparam logic [15:0] P_CTRL = 16'h0020, P_ROM = 16'h0032, P_MODE = 16'h0404,
                          P_MAP = 16'h0480, P_MASK = 16'h05C0, P_STAT = 16'h05C2,
                          P_GLYPH = 16'hFF99;

  logic clk = 1'b0, rstN = 1'b0;
  logic [15:0] portAddr = '0;
  logic [7:0] portWrData = '0, portRdData;
  logic portWr = 1'b0, portRd = 1'b0;
  logic extNmiIn = 1'b0, cpuResetNotify = 1'b0, romDataIn = 1'b0;
  logic nmiVecProtect, powerOffReq, vramMode, dictSel, romSel, glyphEn;
  logic romCs, romClk, romRst, nmiOut;

  int total = 0, bad = 0;
  logic [7:0] rv;

  always #4 clk = ~clk;

  sys_ctrl_regs i_sys_ctrl_regs (
    .clk(clk), .rstN(rstN), .portAddr(portAddr), .portWrData(portWrData),
    .portWr(portWr), .portRd(portRd), .portRdData(portRdData), .extNmiIn(extNmiIn),
    .cpuResetNotify(cpuResetNotify), .romDataIn(romDataIn),
    .nmiVecProtect(nmiVecProtect), .powerOffReq(powerOffReq), .vramMode(vramMode),
    .dictSel(dictSel), .romSel(romSel), .glyphEn(glyphEn), .romCs(romCs),
    .romClk(romClk), .romRst(romRst), .nmiOut(nmiOut)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    portAddr = a; portWrData = d; portWr = 1'b1;
    @(negedge clk);
    portWr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    portAddr = a; portRd = 1'b1;
    #1 d = portRdData;
    @(negedge clk);
    portRd = 1'b0;
  endtask

  function automatic bit isDefined(input logic [15:0] a);
    return (a == P_CTRL) || (a == P_ROM) || (a == P_MODE) || (a == P_MAP) ||
           (a == P_MASK) || (a == P_STAT) || (a == P_GLYPH);
  endfunction

  initial begin
    #(8 * 200000);
    bad++; total++;
    $display("FAIL watchdog actual=%02h expected=%02h", 8'h00, 8'h01);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R12 reset state
    chk("R12 vramMode", {7'b0, vramMode}, 8'h00);
    chk("R12 dictSel", {7'b0, dictSel}, 8'h00);
    chk("R12 romSel", {7'b0, romSel}, 8'h01);
    chk("R12 romCs", {7'b0, romCs}, 8'h01);
    chk("R12 romClk/romRst", {6'b0, romClk, romRst}, 8'h00);
    chk("R12 nmiVecProtect", {7'b0, nmiVecProtect}, 8'h00);
    chk("R11 idle read data", portRdData, 8'h00);
    rd(P_CTRL, rv);  chk("R12 control flags", rv, 8'h00);
    rd(P_MASK, rv);  chk("R12 nmi masked", rv, 8'h00);

    // R1 R2 R3 control port sweep
    for (int d = 0; d < 256; d++) begin
      logic [7:0] dv;
      dv = 8'(d);
      @(negedge clk);
      portAddr = P_CTRL; portWrData = dv; portWr = 1'b1;
      @(negedge clk);
      portWr = 1'b0;
      chk("R3 pulse high", {7'b0, powerOffReq}, {7'b0, dv[6]});
      chk("R1 nmiVecProtect", {7'b0, nmiVecProtect}, {7'b0, dv[7]});
      @(negedge clk);
      chk("R3 pulse ends", {7'b0, powerOffReq}, 8'h00);
      rd(P_CTRL, rv); chk("R1 R2 flags", rv, {5'b0, dv[6], 1'b0, dv[0]});
      rd(P_CTRL, rv); chk("R2 cleared", rv, {5'b0, dv[6], 2'b00});
    end

    // R4 mode port
    for (int d = 0; d < 256; d++) begin
      logic [7:0] dv;
      dv = 8'(d);
      wr(P_MODE, dv);
      chk("R4 vramMode", {7'b0, vramMode}, {7'b0, ~dv[7]});
      rd(P_MODE, rv); chk("R4 readback", rv, dv[7] ? 8'h80 : 8'h00);
    end

    // R5 map port
    for (int d = 0; d < 256; d++) begin
      logic [7:0] dv;
      dv = 8'(d);
      wr(P_MAP, dv);
      chk("R5 dictSel/romSel", {6'b0, dictSel, romSel}, {6'b0, dv[0], ~dv[1]});
      rd(P_MAP, rv); chk("R5 readback", rv, {6'b0, dv[1], dv[0]});
    end

    // R8 serial ROM port
    for (int d = 0; d < 256; d++) begin
      logic [7:0] dv;
      dv = 8'(d);
      romDataIn = dv[2];
      wr(P_ROM, dv);
      chk("R8 pins", {5'b0, romCs, romClk, romRst}, {5'b0, ~dv[5], dv[6], dv[7]});
      rd(P_ROM, rv); chk("R8 readback", rv, {dv[7], dv[6], 5'b0, dv[2]});
    end

    // R9 glyph port
    for (int d = 0; d < 256; d++) begin
      logic [7:0] dv;
      dv = 8'(d);
      wr(P_GLYPH, dv);
      rd(P_GLYPH, rv); chk("R9 readback", rv, {7'b0, dv[0]});
    end

    // R6 R7 mask and NMI level combinations
    for (int d = 0; d < 256; d++) begin
      logic [7:0] dv;
      dv = 8'(d);
      wr(P_MASK, dv);
      rd(P_MASK, rv); chk("R6 mask readback", rv, dv[3] ? 8'h08 : 8'h00);
      for (int lv = 0; lv < 2; lv++) begin
        @(negedge clk);
        extNmiIn = lv[0];
        @(negedge clk);
        chk("R7 nmiOut", {7'b0, nmiOut}, {7'b0, lv[0] & dv[3]});
        rd(P_STAT, rv); chk("R7 status", rv, lv[0] ? 8'h08 : 8'h00);
      end
      @(negedge clk);
      extNmiIn = 1'b0;
    end

    // R10 notification restores mapping bits
    wr(P_MAP, 8'h03);
    wr(P_GLYPH, 8'h01);
    wr(P_CTRL, 8'h80);
    @(negedge clk);
    cpuResetNotify = 1'b1;
    @(negedge clk);
    cpuResetNotify = 1'b0;
    chk("R10 restored bits", {4'b0, romSel, dictSel, nmiVecProtect, glyphEn}, 8'h08);
    rd(P_CTRL, rv); chk("R10 hw flag set", rv, 8'h02);
    rd(P_CTRL, rv); chk("R2 hw flag cleared", rv, 8'h00);

    // R10 notification beats same-cycle read and write
    @(negedge clk);
    portAddr = P_MAP; portWrData = 8'h03; portWr = 1'b1; cpuResetNotify = 1'b1;
    @(negedge clk);
    portWr = 1'b0; cpuResetNotify = 1'b0;
    chk("R10 beats write", {6'b0, romSel, dictSel}, 8'h02);
    @(negedge clk);
    portAddr = P_CTRL; portRd = 1'b1; cpuResetNotify = 1'b1;
    @(negedge clk);
    portRd = 1'b0; cpuResetNotify = 1'b0;
    rd(P_CTRL, rv); chk("R10 beats clear", rv, 8'h02);

    // R11 undefined ports read 0xFF
    for (int a = 0; a < 16'h0800; a++) begin
      if (!isDefined(16'(a))) begin
        rd(16'(a), rv); chk("R11 undefined low", rv, 8'hFF);
      end
    end
    for (int a = 16'hFF80; a <= 16'hFFFF; a++) begin
      if (!isDefined(16'(a))) begin
        rd(16'(a), rv); chk("R11 undefined high", rv, 8'hFF);
      end
    end
    @(negedge clk);
    chk("R11 idle after reads", portRdData, 8'h00);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule